// File: doc/BRIEF.md
# Status-Polled Flash Bank Sequencer

This block erases or programs one bank of a byte-wide flash device that is driven by command writes and reports progress through a status register. A single `start` pulse, with an operation select and a bank number, launches a complete job. For an erase, the block sends a two-step erase command to the bank base. For a program, it fetches each byte from a data source, sends a program-setup command, waits a fixed number of clock cycles, and then writes the byte. After every erase or byte write it polls the device: it writes a status-request command to the bank base, reads the base back, and repeats until the ready bit shows up or a poll budget runs out.

When the erase or the byte loop ends, the block returns the device to array-read mode with a clear-status write followed by a read-mode write. It then reads the whole bank in ascending order and compares each byte with the expected value. For an erase the expected value is all ones. For a program it is the byte from the data source.

Three sticky outcome flags are held until the next `start`: a verify mismatch, a poll timeout, and the error bits seen in the status words. A one-cycle `done` pulse marks the end of each job.

Top module: `flashseq_top`

## Requirements
- R1: All flash accesses of a job use address `bankSel * BANK_BYTES + offset`, with `bankSel` in the upper address bits. Command and status accesses use offset 0, and no access reaches another bank.
- R2: An erase starts with a write of 0x20 to the bank base, followed on the next cycle by a write of 0xD0 to the bank base.
- R3: Programming handles every offset from 0 upward. For each one, the block reads the data source at that offset, writes 0x40 to the target address, stays idle for exactly GAP_CYCLES cycles, and then writes the source byte to the same address.
- R4: Each poll writes 0x70 to the bank base and reads the bank base on the next cycle. A read value with bit 7 set ends the poll. Otherwise the poll repeats.
- R5: After POLL_LIMIT polls with bit 7 clear, `timeout` sets and polling stops. During programming, no further bytes are written after a timeout.
- R6: After an erase or the program loop, including one ended by a timeout, the block writes 0x50 and then 0xFF to the bank base on consecutive cycles.
- R7: Verify reads every offset from 0 to BANK_BYTES-1 in ascending order. An erase expects 0xFF at each offset and a program expects the source byte. Any mismatch sets `verifyErr`.
- R8: For each status read with bit 7 set, bits 5..3 of that read are ORed into `statusErr[2:0]`, with `statusErr[0]` taking bit 3.
- R9: `done` is high for exactly one cycle at the end of a job. The three flags clear at an accepted `start` and otherwise hold. A `start` while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `flashWe`, `flashRe`, `verifyErr`, `timeout` and `statusErr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| opProgram | input | 1 | 1 = program bank, 0 = erase bank |
| bankSel | input | BANK_W | Bank number, captured at start |
| flashAddr | output | BANK_W+OFS_W | Flash byte address |
| flashWdata | output | 8 | Flash write data or command byte |
| flashWe | output | 1 | Flash write strobe, one cycle per write |
| flashRe | output | 1 | Flash read strobe; data expected on flashRdata the next cycle |
| flashRdata | input | 8 | Flash read data |
| srcAddr | output | OFS_W | Data-source byte offset |
| srcRe | output | 1 | Data-source read strobe; data expected the next cycle |
| srcData | input | 8 | Data-source byte |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| verifyErr | output | 1 | Read-back mismatch seen |
| timeout | output | 1 | Poll budget exhausted |
| statusErr | output | 3 | Accumulated status error bits 5..3 |

## Verification
The bench drives a behavioural flash model. In the model, ready appears after a set number of status reads, a chosen cell can be stuck low on one bit, error bits can be injected into status, and the ready bit can be held off forever.

A clean erase with one bank preloaded checks the command order and bank isolation. A clean program with a position-dependent source pattern checks per-byte data placement, the exact setup-to-data gap and the poll count per byte. The stuck cell separates a verify mismatch from a timeout under both operations. The permanently busy device separates the poll budget and the stop of byte writes from the wrap-up sequence, which must still run. Injected status bits show that error bits are gathered only from ready words, and a second `start` during a job shows that a busy request is dropped.

// File: rtl/flashseq_pkg.sv
package flashseq_pkg;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_CLEAR       = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] ERASED_BYTE     = 8'hFF;

  localparam int READY_BIT = 7;
  localparam int ERR_LO    = 3;
  localparam int ERR_W     = 3;

  // which byte the datapath places on the write bus
  typedef enum logic [2:0] {
    WS_ERASE_SETUP,
    WS_ERASE_GO,
    WS_PROG_SETUP,
    WS_DATA,
    WS_STATUS,
    WS_CLEAR,
    WS_READ_ARRAY
  } wsel_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SRC,
    S_LOAD,
    S_CMD1,
    S_GAP,
    S_CMD2,
    S_PCMD,
    S_PRD,
    S_PEVAL,
    S_CLR,
    S_RST,
    S_VRD,
    S_VEVAL,
    S_DONE
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  wr;
    logic  rd;
    wsel_e wsel;
    logic  atTarget;
    logic  srcRd;
    logic  initOp;
    logic  nextAddr;
    logic  clrAddr;
    logic  gapLoad;
    logic  pollClr;
    logic  pollInc;
    logic  dataLoad;
    logic  statusEval;
    logic  verifyEval;
  } seq_ctl_t;

endpackage

// File: rtl/flashseq_ctrl.sv
module flashseq_ctrl
  import flashseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     opProgram,
  input  logic     lastAddr,
  input  logic     pollExpired,
  input  logic     readyBit,
  input  logic     gapDone,
  output seq_ctl_t ctl,
  output logic     isProg,
  output logic     busy,
  output logic     done
);

  seq_state_e state, nextState;
  logic isProgQ;

  assign isProg = isProgQ;
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      isProgQ <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && start) isProgQ <= opProgram;
    end
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctl.initOp = 1'b1;
          nextState  = opProgram ? S_SRC : S_CMD1;
        end
      end
      S_SRC: begin
        ctl.srcRd = 1'b1;
        nextState = S_LOAD;
      end
      S_LOAD: begin
        ctl.dataLoad = 1'b1;
        nextState    = S_CMD1;
      end
      S_CMD1: begin
        ctl.wr       = 1'b1;
        ctl.wsel     = isProgQ ? WS_PROG_SETUP : WS_ERASE_SETUP;
        ctl.atTarget = isProgQ;
        ctl.gapLoad  = 1'b1;
        nextState    = isProgQ ? S_GAP : S_CMD2;
      end
      S_GAP: begin
        if (gapDone) nextState = S_CMD2;
      end
      S_CMD2: begin
        ctl.wr       = 1'b1;
        ctl.wsel     = isProgQ ? WS_DATA : WS_ERASE_GO;
        ctl.atTarget = isProgQ;
        ctl.pollClr  = 1'b1;
        nextState    = S_PCMD;
      end
      S_PCMD: begin
        ctl.wr      = 1'b1;
        ctl.wsel    = WS_STATUS;
        ctl.pollInc = 1'b1;
        nextState   = S_PRD;
      end
      S_PRD: begin
        ctl.rd    = 1'b1;
        nextState = S_PEVAL;
      end
      S_PEVAL: begin
        ctl.statusEval = 1'b1;
        if (readyBit) begin
          if (isProgQ && !lastAddr) begin
            ctl.nextAddr = 1'b1;
            nextState    = S_SRC;
          end else begin
            nextState = S_CLR;
          end
        end else if (pollExpired) begin
          nextState = S_CLR;
        end else begin
          nextState = S_PCMD;
        end
      end
      S_CLR: begin
        ctl.wr      = 1'b1;
        ctl.wsel    = WS_CLEAR;
        ctl.clrAddr = 1'b1;
        nextState   = S_RST;
      end
      S_RST: begin
        ctl.wr    = 1'b1;
        ctl.wsel  = WS_READ_ARRAY;
        nextState = S_VRD;
      end
      S_VRD: begin
        ctl.rd       = 1'b1;
        ctl.atTarget = 1'b1;
        ctl.srcRd    = isProgQ;
        nextState    = S_VEVAL;
      end
      S_VEVAL: begin
        ctl.verifyEval = 1'b1;
        if (lastAddr) begin
          nextState = S_DONE;
        end else begin
          ctl.nextAddr = 1'b1;
          nextState    = S_VRD;
        end
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  // R9: end-of-job pulse lasts one cycle and only appears inside a job
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_in_job_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy && !ctl.wr && !ctl.rd);

endmodule

// File: rtl/flashseq_dp.sv
module flashseq_dp
  import flashseq_pkg::*;
#(
  parameter int BANK_W     = 1,
  parameter int OFS_W      = 13,
  parameter int POLL_LIMIT = 1000000,
  parameter int GAP_CYCLES = 250,
  parameter int POLL_W     = 20,
  parameter int GAP_W      = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seq_ctl_t                ctl,
  input  logic                    isProg,
  input  logic [BANK_W-1:0]       bankSel,
  input  logic [7:0]              flashRdata,
  input  logic [7:0]              srcData,
  output logic [BANK_W+OFS_W-1:0] flashAddr,
  output logic [7:0]              flashWdata,
  output logic                    flashWe,
  output logic                    flashRe,
  output logic [OFS_W-1:0]        srcAddr,
  output logic                    srcRe,
  output logic                    lastAddr,
  output logic                    pollExpired,
  output logic                    readyBit,
  output logic                    gapDone,
  output logic                    verifyErr,
  output logic                    timeout,
  output logic [ERR_W-1:0]        statusErr
);

  logic [BANK_W-1:0] bankQ;
  logic [OFS_W-1:0]  addrQ;
  logic [7:0]        dataQ;
  logic [POLL_W-1:0] pollCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [7:0]        expectByte;

  assign flashAddr = {bankQ, (ctl.atTarget ? addrQ : {OFS_W{1'b0}})};
  assign flashWe   = ctl.wr;
  assign flashRe   = ctl.rd;
  assign srcAddr   = addrQ;
  assign srcRe     = ctl.srcRd;

  always_comb begin
    unique case (ctl.wsel)
      WS_ERASE_SETUP: flashWdata = CMD_ERASE_SETUP;
      WS_ERASE_GO:    flashWdata = CMD_ERASE_GO;
      WS_PROG_SETUP:  flashWdata = CMD_PROG_SETUP;
      WS_DATA:        flashWdata = dataQ;
      WS_STATUS:      flashWdata = CMD_STATUS;
      WS_CLEAR:       flashWdata = CMD_CLEAR;
      WS_READ_ARRAY:  flashWdata = CMD_READ_ARRAY;
      default:        flashWdata = CMD_READ_ARRAY;
    endcase
  end

  assign lastAddr    = &addrQ;
  assign pollExpired = (pollCnt >= POLL_W'(POLL_LIMIT));
  assign readyBit    = flashRdata[READY_BIT];
  assign gapDone     = (gapCnt == '0);
  assign expectByte  = isProg ? srcData : ERASED_BYTE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ     <= '0;
      addrQ     <= '0;
      dataQ     <= '0;
      pollCnt   <= '0;
      gapCnt    <= '0;
      verifyErr <= 1'b0;
      timeout   <= 1'b0;
      statusErr <= '0;
    end else begin
      if (ctl.initOp) begin
        bankQ     <= bankSel;
        addrQ     <= '0;
        pollCnt   <= '0;
        verifyErr <= 1'b0;
        timeout   <= 1'b0;
        statusErr <= '0;
      end else if (ctl.clrAddr) begin
        addrQ <= '0;
      end else if (ctl.nextAddr) begin
        addrQ <= addrQ + 1'b1;
      end

      if (ctl.dataLoad) dataQ <= srcData;

      if (ctl.gapLoad)        gapCnt <= GAP_W'(GAP_CYCLES - 1);
      else if (gapCnt != '0)  gapCnt <= gapCnt - 1'b1;

      if (ctl.pollClr)      pollCnt <= '0;
      else if (ctl.pollInc) pollCnt <= pollCnt + 1'b1;

      if (ctl.statusEval) begin
        if (readyBit) statusErr <= statusErr | flashRdata[ERR_LO +: ERR_W];
        else if (pollExpired) timeout <= 1'b1;
      end

      if (ctl.verifyEval && (flashRdata != expectByte)) verifyErr <= 1'b1;
    end
  end

  // R5: the poll counter never passes its budget, and a timeout is only raised at it
  assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= POLL_W'(POLL_LIMIT));
  assert_timeout_at_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeout) |-> pollCnt == POLL_W'(POLL_LIMIT));

endmodule

// File: rtl/flashseq_top.sv
module flashseq_top
  import flashseq_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int NUM_BANKS  = 2,
  parameter int POLL_LIMIT = 1000000,
  parameter int GAP_CYCLES = 250,
  localparam int OFS_W  = $clog2(BANK_BYTES),
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int FA_W   = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opProgram,
  input  logic [BANK_W-1:0] bankSel,
  output logic [FA_W-1:0]   flashAddr,
  output logic [7:0]        flashWdata,
  output logic              flashWe,
  output logic              flashRe,
  input  logic [7:0]        flashRdata,
  output logic [OFS_W-1:0]  srcAddr,
  output logic              srcRe,
  input  logic [7:0]        srcData,
  output logic              busy,
  output logic              done,
  output logic              verifyErr,
  output logic              timeout,
  output logic [ERR_W-1:0]  statusErr
);

  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int GAP_W  = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES + 1) : 1;

  seq_ctl_t ctl;
  logic isProg, lastAddr, pollExpired, readyBit, gapDone;

  flashseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .opProgram  (opProgram),
    .lastAddr   (lastAddr),
    .pollExpired(pollExpired),
    .readyBit   (readyBit),
    .gapDone    (gapDone),
    .ctl        (ctl),
    .isProg     (isProg),
    .busy       (busy),
    .done       (done)
  );

  flashseq_dp #(
    .BANK_W    (BANK_W),
    .OFS_W     (OFS_W),
    .POLL_LIMIT(POLL_LIMIT),
    .GAP_CYCLES(GAP_CYCLES),
    .POLL_W    (POLL_W),
    .GAP_W     (GAP_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .isProg     (isProg),
    .bankSel    (bankSel),
    .flashRdata (flashRdata),
    .srcData    (srcData),
    .flashAddr  (flashAddr),
    .flashWdata (flashWdata),
    .flashWe    (flashWe),
    .flashRe    (flashRe),
    .srcAddr    (srcAddr),
    .srcRe      (srcRe),
    .lastAddr   (lastAddr),
    .pollExpired(pollExpired),
    .readyBit   (readyBit),
    .gapDone    (gapDone),
    .verifyErr  (verifyErr),
    .timeout    (timeout),
    .statusErr  (statusErr)
  );

  // R2: the erase confirm byte is always preceded by the erase setup byte
  assert_erase_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wr && ctl.wsel == WS_ERASE_GO) |->
      ($past(flashWe) && $past(flashWdata) == CMD_ERASE_SETUP && $past(flashAddr) == flashAddr));

  // R3: the program setup write is followed by at least one idle cycle
  assert_setup_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wr && ctl.wsel == WS_PROG_SETUP) |=> !flashWe);

  // R4: a status request is followed by a read of the same address
  assert_poll_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wr && ctl.wsel == WS_STATUS) |=> (flashRe && flashAddr == $past(flashAddr)));

  // R6: clear status is followed by the return to array read at the same address
  assert_wrapup_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wr && ctl.wsel == WS_CLEAR) |=>
      (flashWe && flashWdata == CMD_READ_ARRAY && flashAddr == $past(flashAddr)));

endmodule

// File: tb/flashseq_top_tb.sv
module flashseq_top_tb;

  localparam int BB    = 16;
  localparam int NB    = 2;
  localparam int PL    = 6;
  localparam int GAP   = 3;
  localparam int OFS_W = 4;
  localparam int FA_W  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, opProgram = 1'b0;
  logic [0:0] bankSel = '0;
  logic [FA_W-1:0] flashAddr;
  logic [7:0] flashWdata, flashRdata = 8'h00;
  logic flashWe, flashRe;
  logic [OFS_W-1:0] srcAddr;
  logic srcRe;
  logic [7:0] srcData = 8'h00;
  logic busy, done, verifyErr, timeout;
  logic [2:0] statusErr;

  always #2 clk = ~clk;

  flashseq_top #(.BANK_BYTES(BB), .NUM_BANKS(NB), .POLL_LIMIT(PL), .GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opProgram(opProgram), .bankSel(bankSel),
    .flashAddr(flashAddr), .flashWdata(flashWdata), .flashWe(flashWe), .flashRe(flashRe),
    .flashRdata(flashRdata), .srcAddr(srcAddr), .srcRe(srcRe), .srcData(srcData),
    .busy(busy), .done(done), .verifyErr(verifyErr), .timeout(timeout), .statusErr(statusErr)
  );

  // ---------------- flash and source models ----------------
  logic [7:0] mem [0:NB*BB-1];
  bit statusMode, expConfirm, expData, forceBusy;
  int busyCnt, eraseDelay = 3, progDelay = 1;
  logic [7:0] injErr = 8'h00;
  int stuckAddr = -1;
  logic [7:0] stuckMask = 8'hFF;

  logic [7:0] wrVal [0:511];
  int wrAddr [0:511];
  int rdAddr [0:511];
  int wrN, rdN, pollW, dataW, gapN, gapBad, lastSetupCyc, offBank, doneCnt;
  bit doneWide, prevDone;
  int cyc = 0;
  int testsRun = 0, testsFailed = 0;
  int expBank;

  function automatic logic [7:0] srcVal(input int a);
    return 8'((a % BB) * 37 + 5);
  endfunction

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (done) begin
      doneCnt = doneCnt + 1;
      if (prevDone) doneWide = 1'b1;
    end
    prevDone = done;
    if (srcRe) srcData = srcVal(int'(srcAddr));
    if (flashWe) begin
      if (wrN < 512) begin wrVal[wrN] = flashWdata; wrAddr[wrN] = int'(flashAddr); end
      wrN = wrN + 1;
      if (int'(flashAddr) / BB != expBank) offBank = offBank + 1;
      if (lastSetupCyc >= 0) begin
        gapN = gapN + 1;
        if (cyc - lastSetupCyc != GAP + 1) gapBad = gapBad + 1;
        lastSetupCyc = -1;
      end
      if (expData) begin
        mem[flashAddr] = flashWdata;
        dataW = dataW + 1;
        expData = 1'b0;
        busyCnt = progDelay;
        statusMode = 1'b1;
      end else begin
        case (flashWdata)
          8'h20: expConfirm = 1'b1;
          8'hD0: if (expConfirm) begin
                   for (int i = 0; i < BB; i++) mem[(int'(flashAddr) / BB) * BB + i] = 8'hFF;
                   busyCnt = eraseDelay;
                   statusMode = 1'b1;
                   expConfirm = 1'b0;
                 end
          8'h40: begin expData = 1'b1; lastSetupCyc = cyc; end
          8'h70: begin statusMode = 1'b1; pollW = pollW + 1; end
          8'hFF: statusMode = 1'b0;
          default: ;
        endcase
      end
    end
    if (flashRe) begin
      if (rdN < 512) rdAddr[rdN] = int'(flashAddr);
      rdN = rdN + 1;
      if (int'(flashAddr) / BB != expBank) offBank = offBank + 1;
      if (statusMode) begin
        if (forceBusy || busyCnt > 0) begin
          flashRdata = 8'h00;
          if (busyCnt > 0) busyCnt = busyCnt - 1;
        end else begin
          flashRdata = 8'h80 | injErr;
        end
      end else begin
        flashRdata = mem[flashAddr] & ((int'(flashAddr) == stuckAddr) ? stuckMask : 8'hFF);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearLogs(input int bank);
    wrN = 0; rdN = 0; pollW = 0; dataW = 0; gapN = 0; gapBad = 0;
    lastSetupCyc = -1; offBank = 0; doneCnt = 0; doneWide = 1'b0;
    statusMode = 1'b0; expConfirm = 1'b0; expData = 1'b0; busyCnt = 0;
    expBank = bank;
  endtask

  task automatic waitDone();
    int guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic runOp(input bit prog, input int bank);
    @(negedge clk);
    clearLogs(bank);
    start = 1'b1; opProgram = prog; bankSel = 1'(bank);
    @(negedge clk);
    start = 1'b0;
    waitDone();
  endtask

  function automatic int verifyOrderBad(input int bank);
    int bad = 0;
    for (int i = 0; i < BB; i++)
      if (rdAddr[rdN - BB + i] != bank * BB + i) bad++;
    return bad;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(!busy && !done && !flashWe && !flashRe, "R10 idle strobes", int'({busy, done, flashWe, flashRe}), 0);
    chk(!verifyErr && !timeout && statusErr == 0, "R10 flags", int'({verifyErr, timeout, statusErr}), 0);
  endtask

  task automatic t_erase();
    int bad0 = 0, bad1 = 0;
    for (int i = 0; i < BB; i++) begin mem[i] = 8'h11; mem[BB + i] = 8'h22; end
    runOp(1'b0, 1);
    chk(wrVal[0] == 8'h20 && wrAddr[0] == BB, "R2 first erase write", int'(wrVal[0]), 32);
    chk(wrVal[1] == 8'hD0 && wrAddr[1] == BB, "R2 second erase write", int'(wrVal[1]), 208);
    chk(offBank == 0, "R1 accesses stay in bank 1", offBank, 0);
    chk(pollW == eraseDelay + 1, "R4 poll count erase", pollW, eraseDelay + 1);
    chk(wrVal[wrN-2] == 8'h50 && wrVal[wrN-1] == 8'hFF && wrAddr[wrN-1] == BB, "R6 wrap-up after erase",
        int'(wrVal[wrN-2]), 80);
    chk(rdN == pollW + BB && verifyOrderBad(1) == 0, "R7 verify reads ascending", rdN, pollW + BB);
    for (int i = 0; i < BB; i++) begin
      if (mem[i] != 8'h11) bad0++;
      if (mem[BB + i] != 8'hFF) bad1++;
    end
    chk(bad1 == 0 && bad0 == 0, "R1 erased only selected bank", bad0 + bad1, 0);
    chk(!verifyErr && !timeout, "R7 clean erase no flags", int'({verifyErr, timeout}), 0);
    chk(doneCnt == 1 && !doneWide, "R9 single done pulse", doneCnt, 1);
  endtask

  task automatic t_program();
    int bad = 0;
    runOp(1'b1, 0);
    chk(dataW == BB, "R3 data writes per byte", dataW, BB);
    for (int i = 0; i < BB; i++) if (mem[i] != srcVal(i)) bad++;
    chk(bad == 0, "R3 programmed contents", bad, 0);
    chk(gapN == BB && gapBad == 0, "R3 setup-to-data gap", gapBad, 0);
    chk(pollW == BB * (progDelay + 1), "R4 poll count program", pollW, BB * (progDelay + 1));
    chk(offBank == 0, "R1 accesses stay in bank 0", offBank, 0);
    chk(!verifyErr && !timeout && statusErr == 0, "R7 clean program no flags",
        int'({verifyErr, timeout, statusErr}), 0);
  endtask

  task automatic t_status_err();
    injErr = 8'h28;
    runOp(1'b0, 0);
    chk(statusErr == 3'b101, "R8 status error bits", int'(statusErr), 5);
    chk(!verifyErr && !timeout, "R8 other flags clear", int'({verifyErr, timeout}), 0);
    injErr = 8'h00;
  endtask

  task automatic t_stuck();
    stuckAddr = BB + 5; stuckMask = 8'h7F;
    runOp(1'b0, 1);
    chk(verifyErr && !timeout, "R7 erase mismatch flagged", int'(verifyErr), 1);
    runOp(1'b1, 1);
    chk(verifyErr && !timeout, "R7 program mismatch flagged", int'(verifyErr), 1);
    stuckAddr = -1; stuckMask = 8'hFF;
    runOp(1'b1, 1);
    chk(!verifyErr, "R9 flag cleared by next start", int'(verifyErr), 0);
  endtask

  task automatic t_timeout();
    forceBusy = 1'b1;
    runOp(1'b1, 0);
    chk(timeout, "R5 timeout raised", int'(timeout), 1);
    chk(dataW == 1, "R5 no bytes after timeout", dataW, 1);
    chk(pollW == PL, "R5 polls equal limit", pollW, PL);
    chk(wrVal[wrN-2] == 8'h50 && wrVal[wrN-1] == 8'hFF && wrAddr[wrN-1] == 0, "R6 wrap-up after timeout",
        int'(wrVal[wrN-1]), 255);
    chk(rdN == PL + BB && verifyOrderBad(0) == 0, "R7 verify after timeout", rdN, PL + BB);
    forceBusy = 1'b0;
    runOp(1'b0, 0);
    chk(!timeout && !verifyErr, "R9 timeout cleared by next start", int'(timeout), 0);
  endtask

  task automatic t_busy_start();
    for (int i = 0; i < BB; i++) mem[i] = 8'h33;
    @(negedge clk);
    clearLogs(1);
    start = 1'b1; opProgram = 1'b0; bankSel = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R9 busy during job", int'(busy), 1);
    start = 1'b1; opProgram = 1'b1; bankSel = 1'b0;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    repeat (5) @(negedge clk);
    chk(doneCnt == 1 && dataW == 0 && !busy, "R9 start while busy ignored", doneCnt, 1);
    chk(mem[0] == 8'h33 && offBank == 0, "R9 other bank untouched", int'(mem[0]), 51);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finishRun();
    end
  end

  initial begin
    forceBusy = 1'b0;
    clearLogs(0);
    for (int i = 0; i < NB * BB; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_erase();
    t_program();
    t_status_err();
    t_stuck();
    t_timeout();
    t_busy_start();
    finishRun();
  end

endmodule